// File: doc/BRIEF.md
# Secure Memory Status Register Controller

This block holds the 8-bit status byte of a command-driven secure memory device. It never sees serial traffic, checksums or memory cells. Neighbouring engines report what happened through single-cycle, synchronous event strobes, plus two busy levels. The block folds those reports into a set of flags and presents them as one byte that the host interface can return at any moment.

The flags cover several things:

- whether the device is busy;
- the write-enable latch, which behaves differently on the SPI and I2C hosts;
- whether the device is fully awake;
- the outcome of the last received command block;
- whether the response buffer holds data;
- whether the latest command failed.

Reading the status byte or the response buffer leaves every flag as it was. A status read taken while the device sleeps or stands by raises a wake request instead. The block also qualifies SPI user-memory writes against the write-enable latch.

All status flags are registered. An event presented in one cycle shows in `status_o` right after the next rising clock edge. `wr_grant_o` and `wake_req_o` are combinational and valid in the same cycle as their strobe.

Top module: `sms_status_ctrl`

## Requirements
- R1: The status byte has this layout: bit 0 busy, bit 1 write-enable, bit 2 not-awake, bit 4 checksum error, bit 6 response ready, bit 7 execution error. Bits 3 and 5 always read 0.
- R2: Bit 0 is 1 in the cycle after either busy input (EEPROM write or command execution) is high, and 0 in the cycle after both are low.
- R3: With `mode_spi` low (I2C host), bit 1 reads 0 whatever instruction strobes arrive.
- R4: In SPI mode bit 1 is 0 after reset. A write-enable instruction sets it on the next edge.
- R5: Bit 1 is cleared on the next edge by any of these: a write instruction, a write-disable instruction, a command-buffer write, an address-reset register write, a reset command, sleep entry or wake start. A clear beats a set in the same cycle. Read and read-status instructions leave it unchanged.
- R6: `wr_grant_o` is high in the cycle of a write instruction only if bit 1 is 1 in that cycle.
- R7: Bit 2 is 1 from reset until a wake-done strobe completes power-up. It is 1 again after sleep or standby entry and during wake-up, and returns to 0 only on wake-done.
- R8: `wake_req_o` is high in the cycle of a status read only while the device is in sleep or standby. It is low for status reads in any other state.
- R9: While the command buffer holds a partial block, the status byte reads exactly 0x10. Any block result (complete, short, bad checksum, overrun) ends the partial state.
- R10: A short count or bad checksum sets bit 4 and leaves bits 7 and 6 at 0. An overrun sets both bit 4 and bit 7. A complete good block clears bit 4.
- R11: Bit 6 is set by a response-buffer fill and cleared by a drain. Fill wins when both arrive together.
- R12: A command error sets bit 7. A command that completes without error clears it.
- R13: Status reads, response-buffer reads and reads past the buffer end change no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| mode_spi | input | 1 | 1 = SPI host, 0 = I2C host |
| ins_wren | input | 1 | SPI write-enable instruction strobe |
| ins_wrdi | input | 1 | SPI write-disable instruction strobe |
| ins_write | input | 1 | SPI user-memory write instruction strobe |
| ins_read | input | 1 | SPI read instruction strobe |
| ins_rdsr | input | 1 | SPI read-status instruction strobe |
| cmdbuf_wr | input | 1 | Command buffer written |
| addr_rst_wr | input | 1 | Address-reset register written |
| reset_cmd | input | 1 | Reset command executed |
| sleep_enter | input | 1 | Device enters sleep |
| standby_enter | input | 1 | Device enters standby |
| wake_start | input | 1 | Wake-up begins from sleep or standby |
| wake_done | input | 1 | Power-up or wake-up complete |
| busy_eeprom | input | 1 | EEPROM write in progress (level) |
| busy_cmd | input | 1 | Command being executed (level) |
| blk_done | input | 1 | Complete block received with good checksum |
| blk_partial | input | 1 | Buffer now holds part of a block |
| blk_short | input | 1 | Block with short count |
| blk_badsum | input | 1 | Block with bad checksum |
| blk_overrun | input | 1 | Block overran the buffer |
| cmd_ok | input | 1 | Command finished without error |
| cmd_err | input | 1 | Command finished with a non-checksum error |
| resp_fill | input | 1 | Response buffer loaded |
| resp_drain | input | 1 | Response buffer emptied |
| stat_rd | input | 1 | Host reads the status byte |
| resp_rd | input | 1 | Host reads the response buffer (any address) |
| status_o | output | 8 | Status byte |
| wr_grant_o | output | 1 | Write instruction permitted |
| wake_req_o | output | 1 | Wake request caused by a status read |

## Verification
The hardest case to reach is the partial-block mask. There the status must collapse to 0x10 while internal flags stay set underneath it, so the stimulus first loads an execution error and a filled response buffer, then delivers a partial block. The hidden flags must reappear once a complete block arrives. The bench also issues same-cycle write-enable set and clear strobes to exercise the clear-first priority. It issues status reads in each power state to separate wake requests from side-effect-free reads.

// File: rtl/sms_pkg.sv
package sms_pkg;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned BIT_BUSY = 0;
  localparam int unsigned BIT_WEN  = 1;
  localparam int unsigned BIT_NAWK = 2;
  localparam int unsigned BIT_CRC  = 4;
  localparam int unsigned BIT_RRDY = 6;
  localparam int unsigned BIT_EERR = 7;
  localparam logic [STAT_W-1:0] PARTIAL_CODE = STAT_W'(1) << BIT_CRC;

  typedef enum logic [1:0] {
    PWR_WAKING  = 2'd0,
    PWR_ACTIVE  = 2'd1,
    PWR_SLEEP   = 2'd2,
    PWR_STANDBY = 2'd3
  } pwr_e;
endpackage

// File: rtl/sms_wen_latch.sv
module sms_wen_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_spi,
  input  logic set_i,
  input  logic clr_i,
  output logic wen_o
);
  logic wen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wen_q <= 1'b0;
    else if (!mode_spi) wen_q <= 1'b0;
    else if (clr_i)     wen_q <= 1'b0;
    else if (set_i)     wen_q <= 1'b1;
  end

  assign wen_o = wen_q & mode_spi;

  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !wen_o);
  assert_set_latches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i && mode_spi) |=> (wen_o || !mode_spi));
endmodule

// File: rtl/sms_power_track.sv
module sms_power_track
  import sms_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  input  logic standby_i,
  input  logic wake_start_i,
  input  logic wake_done_i,
  input  logic stat_rd_i,
  output logic not_awake_o,
  output logic wake_req_o
);
  pwr_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (sleep_i)
      st_d = PWR_SLEEP;
    else if (standby_i)
      st_d = PWR_STANDBY;
    else if (wake_done_i && st_q == PWR_WAKING)
      st_d = PWR_ACTIVE;
    else if (wake_start_i && (st_q == PWR_SLEEP || st_q == PWR_STANDBY))
      st_d = PWR_WAKING;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PWR_WAKING;
    else        st_q <= st_d;
  end

  assign not_awake_o = (st_q != PWR_ACTIVE);
  assign wake_req_o  = stat_rd_i && (st_q == PWR_SLEEP || st_q == PWR_STANDBY);

  assert_wake_req_asleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |-> not_awake_o);
  assert_sleep_not_awake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i || standby_i) |=> not_awake_o);
endmodule

// File: rtl/sms_block_flags.sv
module sms_block_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  input  logic partial_i,
  input  logic short_i,
  input  logic badsum_i,
  input  logic overrun_i,
  input  logic cmd_ok_i,
  input  logic cmd_err_i,
  input  logic fill_i,
  input  logic drain_i,
  output logic crc_o,
  output logic eerr_o,
  output logic rrdy_o,
  output logic part_o
);
  logic sum_fail;
  logic any_result;

  assign sum_fail   = short_i | badsum_i;
  assign any_result = done_i | sum_fail | overrun_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_o  <= 1'b0;
      eerr_o <= 1'b0;
      rrdy_o <= 1'b0;
      part_o <= 1'b0;
    end else begin
      if (any_result)     part_o <= 1'b0;
      else if (partial_i) part_o <= 1'b1;

      if (sum_fail | overrun_i) crc_o <= 1'b1;
      else if (done_i)          crc_o <= 1'b0;

      if (overrun_i | cmd_err_i) eerr_o <= 1'b1;
      else if (sum_fail)         eerr_o <= 1'b0;
      else if (cmd_ok_i)         eerr_o <= 1'b0;

      if (sum_fail)     rrdy_o <= 1'b0;
      else if (fill_i)  rrdy_o <= 1'b1;
      else if (drain_i) rrdy_o <= 1'b0;
    end
  end

  assert_overrun_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_i |=> (crc_o && eerr_o));
  assert_badsum_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (badsum_i && !overrun_i && !cmd_err_i) |=> (crc_o && !eerr_o && !rrdy_o));
  assert_ok_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok_i && !cmd_err_i && !overrun_i) |=> !eerr_o);
  assert_fill_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_i && !sum_fail) |=> rrdy_o);
endmodule

// File: rtl/sms_status_ctrl.sv
module sms_status_ctrl
  import sms_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_spi,
  input  logic              ins_wren,
  input  logic              ins_wrdi,
  input  logic              ins_write,
  input  logic              ins_read,
  input  logic              ins_rdsr,
  input  logic              cmdbuf_wr,
  input  logic              addr_rst_wr,
  input  logic              reset_cmd,
  input  logic              sleep_enter,
  input  logic              standby_enter,
  input  logic              wake_start,
  input  logic              wake_done,
  input  logic              busy_eeprom,
  input  logic              busy_cmd,
  input  logic              blk_done,
  input  logic              blk_partial,
  input  logic              blk_short,
  input  logic              blk_badsum,
  input  logic              blk_overrun,
  input  logic              cmd_ok,
  input  logic              cmd_err,
  input  logic              resp_fill,
  input  logic              resp_drain,
  input  logic              stat_rd,
  input  logic              resp_rd,
  output logic [STAT_W-1:0] status_o,
  output logic              wr_grant_o,
  output logic              wake_req_o
);
  logic busy_q, wen, nawk, crc, eerr, rrdy, part;
  logic wen_clr;
  logic [STAT_W-1:0] raw;

  assign wen_clr = ins_write | ins_wrdi | cmdbuf_wr | addr_rst_wr |
                   reset_cmd | sleep_enter | wake_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_eeprom | busy_cmd;
  end

  sms_wen_latch u_wen (
    .clk(clk), .rst_n(rst_n), .mode_spi(mode_spi),
    .set_i(ins_wren), .clr_i(wen_clr), .wen_o(wen)
  );

  sms_power_track u_pwr (
    .clk(clk), .rst_n(rst_n),
    .sleep_i(sleep_enter), .standby_i(standby_enter),
    .wake_start_i(wake_start), .wake_done_i(wake_done),
    .stat_rd_i(stat_rd), .not_awake_o(nawk), .wake_req_o(wake_req_o)
  );

  sms_block_flags u_blk (
    .clk(clk), .rst_n(rst_n),
    .done_i(blk_done), .partial_i(blk_partial), .short_i(blk_short),
    .badsum_i(blk_badsum), .overrun_i(blk_overrun),
    .cmd_ok_i(cmd_ok), .cmd_err_i(cmd_err),
    .fill_i(resp_fill), .drain_i(resp_drain),
    .crc_o(crc), .eerr_o(eerr), .rrdy_o(rrdy), .part_o(part)
  );

  always_comb begin
    raw           = '0;
    raw[BIT_BUSY] = busy_q;
    raw[BIT_WEN]  = wen;
    raw[BIT_NAWK] = nawk;
    raw[BIT_CRC]  = crc;
    raw[BIT_RRDY] = rrdy;
    raw[BIT_EERR] = eerr;
  end

  assign status_o   = part ? PARTIAL_CODE : raw;
  assign wr_grant_o = ins_write & wen;

  logic quiet;
  assign quiet = !(ins_wren | wen_clr | standby_enter | wake_done |
                   blk_done | blk_partial | blk_short | blk_badsum |
                   blk_overrun | cmd_ok | cmd_err | resp_fill | resp_drain) &&
                 ((busy_eeprom | busy_cmd) == busy_q);

  assert_reads_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_rd || resp_rd || ins_read || ins_rdsr) && quiet)
      |=> ($stable(status_o) || !$stable(mode_spi)));
  assert_write_drops_wen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant_o |=> !status_o[BIT_WEN]);
  assert_partial_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_partial && !(blk_done | blk_short | blk_badsum | blk_overrun))
      |=> (status_o == PARTIAL_CODE));
  assert_rsvd_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[3] && !status_o[5]);
endmodule

// File: tb/sms_status_ctrl_test.sv
`timescale 1ns/1ps
module sms_status_ctrl_test;
  localparam int E_WREN=0, E_WRDI=1, E_WRITE=2, E_READ=3, E_RDSR=4, E_CMDBUF=5,
                 E_ADDRRST=6, E_RSTCMD=7, E_SLEEP=8, E_STBY=9, E_WSTART=10,
                 E_WDONE=11, E_BDONE=12, E_BPART=13, E_BSHORT=14, E_BBAD=15,
                 E_BOVR=16, E_COK=17, E_CERR=18, E_FILL=19, E_DRAIN=20,
                 E_STRD=21, E_RESPRD=22, NEV=23;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_spi = 1'b1, busy_eeprom = 1'b0, busy_cmd = 1'b0;
  logic [NEV-1:0] ev = '0;
  logic [7:0] status_o;
  logic wr_grant_o, wake_req_o;

  always #2.5 clk = ~clk;

  sms_status_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mode_spi(mode_spi),
    .ins_wren(ev[E_WREN]), .ins_wrdi(ev[E_WRDI]), .ins_write(ev[E_WRITE]),
    .ins_read(ev[E_READ]), .ins_rdsr(ev[E_RDSR]), .cmdbuf_wr(ev[E_CMDBUF]),
    .addr_rst_wr(ev[E_ADDRRST]), .reset_cmd(ev[E_RSTCMD]),
    .sleep_enter(ev[E_SLEEP]), .standby_enter(ev[E_STBY]),
    .wake_start(ev[E_WSTART]), .wake_done(ev[E_WDONE]),
    .busy_eeprom(busy_eeprom), .busy_cmd(busy_cmd),
    .blk_done(ev[E_BDONE]), .blk_partial(ev[E_BPART]), .blk_short(ev[E_BSHORT]),
    .blk_badsum(ev[E_BBAD]), .blk_overrun(ev[E_BOVR]),
    .cmd_ok(ev[E_COK]), .cmd_err(ev[E_CERR]),
    .resp_fill(ev[E_FILL]), .resp_drain(ev[E_DRAIN]),
    .stat_rd(ev[E_STRD]), .resp_rd(ev[E_RESPRD]),
    .status_o(status_o), .wr_grant_o(wr_grant_o), .wake_req_o(wake_req_o)
  );

  int tests = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  // reference model from the requirements
  logic m_wen = 0, m_busy = 0, m_crc = 0, m_eerr = 0, m_rrdy = 0, m_part = 0;
  int   m_pwr = 0; // 0 waking, 1 active, 2 sleep, 3 standby

  function automatic logic [7:0] m_status();
    if (m_part) return 8'h10;
    return {m_eerr, m_rrdy, 1'b0, m_crc, 1'b0, (m_pwr != 1), m_wen, m_busy};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare registered status away from the rising edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) check(tag_q.pop_front(), status_o, exp_q.pop_front());
  end

  // driver: apply one cycle of strobes, update model, push expectation
  task automatic step(input logic [NEV-1:0] e, input string tag);
    logic clr, sumf;
    @(negedge clk);
    ev = e;
    #1;
    if (e[E_WRITE]) check({tag, " R6 grant"}, {7'b0, wr_grant_o}, {7'b0, m_wen});
    if (e[E_STRD])
      check({tag, " R8 wake_req"}, {7'b0, wake_req_o}, {7'b0, (m_pwr == 2 || m_pwr == 3)});
    clr = e[E_WRITE] | e[E_WRDI] | e[E_CMDBUF] | e[E_ADDRRST] | e[E_RSTCMD] |
          e[E_SLEEP] | e[E_WSTART];
    if (!mode_spi) m_wen = 0; else if (clr) m_wen = 0; else if (e[E_WREN]) m_wen = 1;
    if (e[E_SLEEP]) m_pwr = 2;
    else if (e[E_STBY]) m_pwr = 3;
    else if (e[E_WDONE] && m_pwr == 0) m_pwr = 1;
    else if (e[E_WSTART] && m_pwr >= 2) m_pwr = 0;
    sumf = e[E_BSHORT] | e[E_BBAD];
    if (sumf | e[E_BOVR] | e[E_BDONE]) m_part = 0; else if (e[E_BPART]) m_part = 1;
    if (sumf | e[E_BOVR]) m_crc = 1; else if (e[E_BDONE]) m_crc = 0;
    if (e[E_BOVR] | e[E_CERR]) m_eerr = 1; else if (sumf | e[E_COK]) m_eerr = 0;
    if (sumf) m_rrdy = 0; else if (e[E_FILL]) m_rrdy = 1; else if (e[E_DRAIN]) m_rrdy = 0;
    m_busy = busy_eeprom | busy_cmd;
    @(posedge clk);
    #1;
    ev = '0;
    exp_q.push_back(m_status());
    tag_q.push_back(tag);
  endtask

  function automatic logic [NEV-1:0] b(input int i);
    return NEV'(1) << i;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset status", status_o, 8'h04);
    rst_n = 1'b1;
    step(b(E_WDONE), "R7 power-up done");
    mode_spi = 1'b0;
    step(b(E_WREN), "R3 i2c wren ignored");
    mode_spi = 1'b1;
    step(b(E_WRITE), "R6 write without wen");
    step(b(E_WREN), "R4 wren sets");
    step(b(E_RDSR) | b(E_READ), "R5 reads keep wen");
    step(b(E_STRD) | b(E_RESPRD), "R13 reads no effect");
    step(b(E_WRITE), "R5 write clears");
    step(b(E_WREN) | b(E_WRDI), "R5 clear beats set");
    step(b(E_WREN), "R4 wren again");
    step(b(E_CMDBUF), "R5 cmdbuf clears");
    step(b(E_WREN), "R4 wren again");
    step(b(E_ADDRRST), "R5 addr reset clears");
    step(b(E_WREN), "R4 wren again");
    step(b(E_RSTCMD), "R5 reset cmd clears");
    busy_eeprom = 1'b1;
    step('0, "R2 busy eeprom");
    busy_eeprom = 1'b0; busy_cmd = 1'b1;
    step('0, "R2 busy cmd");
    busy_cmd = 1'b0;
    step('0, "R2 idle");
    step(b(E_CERR), "R12 error sets");
    step(b(E_FILL), "R11 fill");
    step(b(E_BPART), "R9 partial masks");
    step(b(E_STRD) | b(E_RESPRD), "R13 reads in partial");
    step(b(E_BDONE), "R9 R10 good block ends partial");
    step(b(E_FILL) | b(E_DRAIN), "R11 fill wins");
    step(b(E_COK), "R12 ok clears");
    step(b(E_BBAD), "R10 bad checksum");
    step(b(E_BDONE), "R10 good block clears crc");
    step(b(E_FILL), "R11 fill");
    step(b(E_BSHORT), "R10 short count");
    step(b(E_FILL), "R11 fill");
    step(b(E_BOVR), "R10 overrun");
    step(b(E_DRAIN), "R11 drain");
    step(b(E_BDONE) | b(E_COK), "R10 R12 recover");
    step(b(E_STRD), "R8 no wake when active");
    step(b(E_WREN), "R4 wren");
    step(b(E_SLEEP), "R5 R7 sleep");
    step(b(E_STRD) | b(E_RESPRD), "R8 R13 read in sleep");
    step(b(E_WSTART), "R7 waking");
    step(b(E_WDONE), "R7 awake");
    step(b(E_STBY), "R7 standby");
    step(b(E_STRD), "R8 read in standby");
    step(b(E_WSTART), "R7 waking from standby");
    step(b(E_WDONE), "R1 R7 awake final");
    repeat (2) @(posedge clk);
    #1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule